// File: doc/BRIEF.md
# Selectable Reference Clock Divider

This block turns an incoming reference clock into the comparison clock used by the frequency synthesizers. A 2-bit select code picks one of four behaviours: divide by 2, divide by 3, divide by 44, or pass the reference straight through. Each divide ratio has a fixed high/low shape. The divide-by-2 output is symmetric. The divide-by-3 and divide-by-44 outputs are high for a single reference cycle and low for the rest of the period.

Besides the divided clock, the block drives a strobe. The strobe marks the reference cycle in which each output period begins. Logic that runs on the reference clock can use it as a clock-enable instead of sampling the divided clock itself.

A new select code is taken only at the edge that ends the running output period. Because of this, a ratio change never produces a shortened high or low phase. The reset is synchronous and active low. It clears the phase counter and forces both outputs low. The internally held ratio returns to divide-by-2.

Top module: `ref_clk_divider`

## Requirements
- R1: A clock edge seen with `rst_n` low clears the phase counter and drives `div_clk` and `div_stb` low; both stay low for as long as reset is held.
- R2: The first clock edge with `rst_n` high after a reset begins a new output period. That period uses the `sel` value present at that edge, and `div_clk` and `div_stb` go high for the following cycle.
- R3: With `sel` = 2'b00, the output period is 2 reference cycles: high for 1 cycle, then low for 1 cycle.
- R4: With `sel` = 2'b01, the output period is 3 reference cycles: high for 1 cycle, then low for 2 cycles.
- R5: With `sel` = 2'b10, the output period is 44 reference cycles: high for 1 cycle, then low for 43 cycles.
- R6: With `sel` = 2'b11 in effect, `div_clk` follows the reference clock level and `div_stb` stays high on every cycle.
- R7: `sel` is sampled only at the edge that ends the running output period. Values that `sel` holds at other edges have no effect on `div_clk` or `div_stb`.
- R8: In the three divide modes, `div_stb` is high for exactly one reference cycle per output period. That cycle is the one in which `div_clk` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 2 | Ratio select: 00 = /2, 01 = /3, 10 = /44, 11 = pass-through |
| div_clk | output | 1 | Divided comparison clock (the reference itself in pass-through) |
| div_stb | output | 1 | One-cycle strobe at each output period start; held high in pass-through |

## Verification
The assertions assume that `sel` and `rst_n` are synchronous to the reference clock and steady around its rising edge. They also assume that reset is low from time zero until the first edges have cleared the state. The bench honours both assumptions by changing every input only at the falling edge. It holds reset low across the first edges, and the noise it puts on `sel` in the middle of a period is always restored before the edge that ends that period. Pass-through is observed in both clock phases, because there `div_clk` is the reference level rather than a registered value.

// File: rtl/refdiv_pkg.sv
// Shared types and ratio lookup helpers for the reference clock divider.
// Assumes the select code is two bits wide and that every ratio is >= 1.
package refdiv_pkg;

    typedef enum logic [1:0] {
        SEL_HALF  = 2'b00,
        SEL_THIRD = 2'b01,
        SEL_LONG  = 2'b10,
        SEL_THRU  = 2'b11
    } refdiv_sel_e;

    // Division ratio selected by a code; pass-through counts as a ratio of one.
    function automatic int unsigned div_of(refdiv_sel_e s, int unsigned d_half,
                                           int unsigned d_third, int unsigned d_long);
        case (s)
            SEL_HALF:  return d_half;
            SEL_THIRD: return d_third;
            SEL_LONG:  return d_long;
            default:   return 1;
        endcase
    endfunction

    // Number of reference cycles the output stays high within one period.
    function automatic int unsigned high_of(refdiv_sel_e s, int unsigned h_half,
                                            int unsigned h_third, int unsigned h_long);
        case (s)
            SEL_HALF:  return h_half;
            SEL_THIRD: return h_third;
            SEL_LONG:  return h_long;
            default:   return 1;
        endcase
    endfunction

    // Largest of three values, used to size the phase counter.
    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/refdiv_mode_reg.sv
// Holds the ratio code in effect for the running output period.
// Assumes the boundary input is high only on the edge that ends a period;
// the incoming code is captured there and nowhere else.
module refdiv_mode_reg
    import refdiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        boundary,
    input  refdiv_sel_e sel_in,
    output refdiv_sel_e mode_q
);

    // Capture the requested code at a period boundary; reset returns to /2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= SEL_HALF;
        end else if (boundary) begin
            mode_q <= sel_in;
        end
    end

    // R7: the active code never moves in the middle of a period.
    a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(mode_q));

endmodule

// File: rtl/refdiv_phase_cnt.sv
// Down-counter giving the remaining reference cycles of the output period.
// A zero count marks the final cycle; the next edge reloads ratio-1.
// Assumes load_val is already decoded from the code that will take effect.
module refdiv_phase_cnt #(
    parameter int unsigned CNT_W    = 6,
    parameter int unsigned MAX_LAST = 43
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             boundary
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Final cycle of a period is flagged when the count reaches zero.
    assign boundary = (cnt_q == '0);

    // Reload at the boundary, otherwise step down by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (boundary) begin
            cnt_q <= load_val;
        end else begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // R5: the count never exceeds the longest ratio minus one.
    a_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_LAST));

endmodule

// File: rtl/refdiv_shaper.sv
// Registers the divided-clock level and the period-start strobe.
// The output is high while the remaining count is at or above the
// threshold (ratio minus high length) of the active code, and is forced
// high on the first cycle of each period. Outputs are flops, so no
// decode glitch reaches the synthesizer comparison input.
module refdiv_shaper #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] thresh,
    output logic             out_q,
    output logic             stb_q
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_dec;
    logic             out_nxt;
    logic             rst_seen;

    // Level for the next cycle within the running period.
    always_comb begin
        cnt_dec = cnt_q - ONE;
        out_nxt = (cnt_dec >= thresh);
    end

    // Start every period high with a strobe; otherwise follow the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
            stb_q <= 1'b0;
        end else if (boundary) begin
            out_q <= 1'b1;
            stb_q <= 1'b1;
        end else begin
            out_q <= out_nxt;
            stb_q <= 1'b0;
        end
    end

    // Remember whether the last edge was a reset edge (checker only).
    always_ff @(posedge clk) begin
        rst_seen <= !rst_n;
    end

    // R1: after a reset edge both registered outputs read low.
    always @(negedge clk) begin
        if (rst_seen === 1'b1) begin
            a_r1_reset_clear: assert (!out_q && !stb_q)
                else $error("reset edge left out_q=%b stb_q=%b", out_q, stb_q);
        end
    end

endmodule

// File: rtl/refdiv_out_mux.sv
// Chooses the registered divided level or, in pass-through, the reference
// clock itself. Assumes the select only changes at a rising reference edge,
// where both candidates are about to be high.
module refdiv_out_mux (
    input  logic ref_clk,
    input  logic thru_act,
    input  logic div_lvl,
    output logic clk_out
);

    // Pass the reference through in bypass, otherwise the shaped level.
    always_comb begin
        clk_out = thru_act ? ref_clk : div_lvl;
    end

endmodule

// File: rtl/ref_clk_divider.sv
// Top of the selectable reference clock divider.
// Divides clk by one of three ratios or passes it through, chosen by sel.
// sel is sampled only at the edge that closes the running period, so the
// output never shows a shortened phase. Assumes sel and rst_n are
// synchronous to clk; reset is synchronous and active low.
module ref_clk_divider
    import refdiv_pkg::*;
#(
    parameter int unsigned DIV_HALF   = 2,
    parameter int unsigned DIV_THIRD  = 3,
    parameter int unsigned DIV_LONG   = 44,
    parameter int unsigned HIGH_HALF  = DIV_HALF / 2,
    parameter int unsigned HIGH_THIRD = 1,
    parameter int unsigned HIGH_LONG  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    output logic       div_clk,
    output logic       div_stb
);

    localparam int unsigned MAX_DIV = max3(DIV_HALF, DIV_THIRD, DIV_LONG);
    localparam int unsigned CNT_W   = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;

    refdiv_sel_e      sel_in;
    refdiv_sel_e      mode_q;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] thresh_act;
    logic [CNT_W-1:0] cnt_q;
    logic             boundary;
    logic             thru_act;
    logic             out_q;
    logic             stb_q;

    // Decode reload value for the incoming code and threshold for the active one.
    always_comb begin
        sel_in     = refdiv_sel_e'(sel);
        load_val   = CNT_W'(div_of(sel_in, DIV_HALF, DIV_THIRD, DIV_LONG) - 1);
        thresh_act = CNT_W'(div_of(mode_q, DIV_HALF, DIV_THIRD, DIV_LONG)
                          - high_of(mode_q, HIGH_HALF, HIGH_THIRD, HIGH_LONG));
        thru_act   = (mode_q == SEL_THRU);
    end

    refdiv_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (boundary),
        .sel_in   (sel_in),
        .mode_q   (mode_q)
    );

    refdiv_phase_cnt #(
        .CNT_W    (CNT_W),
        .MAX_LAST (MAX_DIV - 1)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_val (load_val),
        .cnt_q    (cnt_q),
        .boundary (boundary)
    );

    refdiv_shaper #(
        .CNT_W (CNT_W)
    ) u_shape (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (boundary),
        .cnt_q    (cnt_q),
        .thresh   (thresh_act),
        .out_q    (out_q),
        .stb_q    (stb_q)
    );

    refdiv_out_mux u_mux (
        .ref_clk  (clk),
        .thru_act (thru_act),
        .div_lvl  (out_q),
        .clk_out  (div_clk)
    );

    assign div_stb = stb_q;

    // R8: in a divide mode the strobe never lasts two cycles.
    a_r8_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_q && !thru_act) |=> !stb_q);

    // R8: every rise of the divided level comes with the strobe.
    a_r8_strobe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_q) |-> stb_q);

    // R6: while pass-through is active the strobe is held high.
    a_r6_thru_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        thru_act |-> stb_q);

endmodule

// File: tb/ref_clk_divider_test.sv
// Scoreboard bench: the driver pushes the expected per-cycle output shape,
// a monitor pops one entry per reference cycle and compares both phases.
module ref_clk_divider_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       div_clk;
    logic       div_stb;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  hi;
        logic  lo;
        logic  stb;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    ref_clk_divider uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .div_clk (div_clk),
        .div_stb (div_stb)
    );

    always #HALF clk = ~clk;

    task automatic check(input string tag, input string what, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, expv, $time);
        end
    endtask

    // Monitor: one expected entry per reference cycle, high phase then low phase.
    always begin
        @(posedge clk);
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            #1;
            check(e.tag, "div_clk high phase", div_clk, e.hi);
            @(negedge clk);
            #1;
            check(e.tag, "div_clk low phase", div_clk, e.lo);
            check(e.tag, "div_stb", div_stb, e.stb);
        end
    end

    // Ratio per select code, from the requirements (R3..R6).
    function automatic int ratio_of(input logic [1:0] code);
        case (code)
            2'b00:   return 2;
            2'b01:   return 3;
            2'b10:   return 44;
            default: return 1;
        endcase
    endfunction

    // Driver: called at a falling edge whose next rising edge ends a period.
    // Applies code, queues the expected shape for the given periods, and
    // optionally puts noise on sel at edges that do not end a period (R7).
    task automatic play(input logic [1:0] code, input int periods,
                        input logic use_noise, input logic [1:0] noise, input string tag);
        int n;
        n = ratio_of(code);
        sel = code;
        for (int p = 0; p < periods; p++) begin
            for (int c = 0; c < n; c++) begin
                exp_t e;
                e.tag = tag;
                if (code == 2'b11) begin
                    e.hi = 1'b1; e.lo = 1'b0; e.stb = 1'b1;
                end else begin
                    e.hi = (c == 0); e.lo = (c == 0); e.stb = (c == 0);
                end
                exp_q.push_back(e);
            end
        end
        for (int edge_n = 1; edge_n <= n * periods; edge_n++) begin
            @(posedge clk);
            @(negedge clk);
            if (use_noise && (edge_n % n != 0)) sel = noise;
            else sel = code;
        end
    endtask

    // Reset at a falling edge and check the cleared outputs (R1).
    task automatic reset_check(input int cycles);
        rst_n = 1'b0;
        for (int k = 0; k < cycles; k++) begin
            @(posedge clk);
            #1;
            check("R1", "div_clk during reset (high phase)", div_clk, 1'b0);
            @(negedge clk);
            #1;
            check("R1", "div_clk during reset (low phase)", div_clk, 1'b0);
            check("R1", "div_stb during reset", div_stb, 1'b0);
        end
        @(negedge clk);
    endtask

    initial begin
        sel   = 2'b00;
        rst_n = 1'b0;
        @(negedge clk);
        reset_check(2);

        // R2: first edge after release starts a /3 period at once.
        rst_n = 1'b1;
        play(2'b01, 1, 1'b0, 2'b00, "R2");

        play(2'b00, 4, 1'b0, 2'b00, "R3");
        play(2'b01, 3, 1'b0, 2'b00, "R4");
        play(2'b10, 2, 1'b0, 2'b00, "R5");
        play(2'b11, 6, 1'b0, 2'b00, "R6");

        // R7: mid-period sel noise is ignored, including the bypass code.
        play(2'b10, 1, 1'b1, 2'b11, "R7");
        play(2'b01, 2, 1'b1, 2'b10, "R7");
        play(2'b00, 1, 1'b0, 2'b00, "R8");
        play(2'b11, 3, 1'b0, 2'b00, "R6");
        play(2'b01, 2, 1'b1, 2'b11, "R8");
        play(2'b11, 2, 1'b0, 2'b00, "R6");
        play(2'b00, 3, 1'b0, 2'b00, "R3");

        // R1: reset in the middle of a long period, then restart with /44.
        sel = 2'b10;
        for (int k = 0; k < 7; k++) @(negedge clk);
        reset_check(3);
        rst_n = 1'b1;
        play(2'b10, 1, 1'b1, 2'b01, "R2");
        play(2'b00, 2, 1'b0, 2'b00, "R3");

        // R1: reset while pass-through is active.
        play(2'b11, 2, 1'b0, 2'b00, "R6");
        reset_check(1);
        rst_n = 1'b1;
        play(2'b00, 2, 1'b0, 2'b00, "R2");

        @(negedge clk);
        @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R8 scoreboard drain: actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule